// File: doc/BRIEF.md
# DMA Request Line Sampler

This block converts external DMA request pins into per-channel transfer requests for a multi-channel DMA controller. Each channel that owns a request pin passes it through a synchronizer and then detects a low level, a high level, a falling edge or a rising edge. A 2-bit sampling code chosen per channel selects which of these four it looks for. A level-mode request follows the pin. An edge-mode request is held pending until the channel engine acknowledges it.

Only the lower channels own a pin. The upper channels keep no sampling code and never raise a request from this block. Each channel also has a request-source select. When that select names an on-chip peripheral or the auto-request source, the pin and its sampling code have no effect on the channel. The sampling codes are written one channel at a time and read back through a combinational read port.

Top module: `dreq_sampler`

## Requirements
- R1: A pin channel's sampling code is set by a write strobe with the channel index and the code. It reads back unchanged. Code 0 detects low level, 1 falling edge, 2 high level and 3 rising edge. Bit 0 of the code selects edge detection and bit 1 selects the active-high polarity.
- R2: Channels at index NUM_PIN_CH and above read their code as 0 and ignore writes to it. Their request output is always 0.
- R3: A channel whose source select is 0 (on-chip peripheral or auto-request) drives its request output low. Pin activity while it is deselected leaves no pending request behind.
- R4: After reset, every sampling code is 0, which is low-level detection.
- R5: Each pin passes through two synchronizing flops. In a level mode the request output reflects the pin two clock edges after the pin changes. In an edge mode, a qualifying edge appears on the request output three edges after the pin changes.
- R6: An edge-mode request stays asserted until the acknowledge for its channel is sampled high. Further edges that arrive while it is pending merge into the same request, so one acknowledge clears them all. An edge detected in the same cycle as an acknowledge leaves the request pending.
- R7: A level-mode request is not latched. It is high exactly while the synchronized pin holds the active level.
- R8: Edges are found by comparing the synchronized sample with the previous one, and that previous sample tracks every cycle. Changing the code while the pin holds a steady level therefore creates no request in the new edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pin_i | input | NUM_PIN_CH | Raw asynchronous request pins, one per pin channel |
| src_ext_i | input | NUM_CH | Per channel: 1 selects the external pin as request source |
| ack_i | input | NUM_CH | Per channel: request accepted by the channel engine |
| mode_wr_en_i | input | 1 | Sampling-code write strobe |
| mode_wr_ch_i | input | $clog2(NUM_CH) | Channel index for the write |
| mode_wr_data_i | input | 2 | Sampling code to write |
| mode_rd_ch_i | input | $clog2(NUM_CH) | Channel index for read-back |
| mode_rd_data_o | output | 2 | Sampling code of the selected channel (0 for channels without a pin) |
| req_o | output | NUM_CH | Per-channel transfer request |

## Verification
The bench builds the block with its defaults of eight channels, four of them with pins and a two-stage synchronizer. This brings in both the pin channels and the channels without a pin that must stay silent and read zero. Random pins, acknowledges, source selects and code writes run against a cycle model in the bench. This exercises merges, acknowledges that collide with new edges, and code changes under a held pin. Directed sequences then pin down each detection mode, the read-back masking and the source gating with literal expected values.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    SMP_LOW  = 2'b00,
    SMP_FALL = 2'b01,
    SMP_HIGH = 2'b10,
    SMP_RISE = 2'b11
  } smp_mode_e;

  function automatic logic mode_is_edge(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_active_high(input logic [1:0] m);
    return m[1];
  endfunction

  // edge qualified by polarity: rising when active-high, falling otherwise
  function automatic logic edge_match(input logic [1:0] m, input logic cur, input logic prv);
    return mode_active_high(m) ? (cur & ~prv) : (~cur & prv);
  endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dreq_chan.sv
module dreq_chan
  import dreq_pkg::*;
#(
  parameter bit HAS_PIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_i,
  input  logic       wr_i,
  input  logic [1:0] wr_mode_i,
  input  logic       src_ext_i,
  input  logic       ack_i,
  output logic [1:0] mode_o,
  output logic       edge_o,
  output logic       pend_o,
  output logic       req_o
);
  logic [1:0] mode_q, mode_d;
  logic       prev_q;
  logic       pend_q, pend_d;
  logic       active;

  assign active = src_ext_i & HAS_PIN;
  assign mode_d = wr_i ? wr_mode_i : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SMP_LOW;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= HAS_PIN ? mode_d : 2'b00;
      prev_q <= smp_i;
      pend_q <= pend_d;
    end
  end

  assign edge_o = active & mode_is_edge(mode_q) & edge_match(mode_q, smp_i, prev_q);
  assign pend_d = edge_o | (pend_q & ~ack_i & active & mode_is_edge(mode_q));

  always_comb begin
    if (mode_is_edge(mode_q)) req_o = active & pend_q;
    else                      req_o = active & (smp_i == mode_active_high(mode_q));
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler
  import dreq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_PIN_CH  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIN_CH-1:0] req_pin_i,
  input  logic [NUM_CH-1:0]     src_ext_i,
  input  logic [NUM_CH-1:0]     ack_i,
  input  logic                  mode_wr_en_i,
  input  logic [CH_W-1:0]       mode_wr_ch_i,
  input  logic [1:0]            mode_wr_data_i,
  input  logic [CH_W-1:0]       mode_rd_ch_i,
  output logic [1:0]            mode_rd_data_o,
  output logic [NUM_CH-1:0]     req_o
);
  logic [NUM_PIN_CH-1:0]   sync_w;
  logic [NUM_CH-1:0][1:0]  mode_w;
  logic [NUM_CH-1:0]       edge_w;
  logic [NUM_CH-1:0]       pend_w;

  dreq_sync #(.W(NUM_PIN_CH), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (req_pin_i),
    .q_o  (sync_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic smp;
    logic wr_hit;
    if (c < NUM_PIN_CH) begin : g_pin
      assign smp = sync_w[c];
    end else begin : g_nopin
      assign smp = 1'b0;
    end
    assign wr_hit = mode_wr_en_i && (mode_wr_ch_i == CH_W'(c));

    dreq_chan #(.HAS_PIN(c < NUM_PIN_CH)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_i    (smp),
      .wr_i     (wr_hit),
      .wr_mode_i(mode_wr_data_i),
      .src_ext_i(src_ext_i[c]),
      .ack_i    (ack_i[c]),
      .mode_o   (mode_w[c]),
      .edge_o   (edge_w[c]),
      .pend_o   (pend_w[c]),
      .req_o    (req_o[c])
    );
  end

  assign mode_rd_data_o = mode_w[mode_rd_ch_i];
endmodule

// File: rtl/dreq_sampler_chk.sv
module dreq_sampler_chk #(
  parameter int NUM_CH     = 8,
  parameter int NUM_PIN_CH = 4,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CH-1:0]     src_ext_i,
  input logic [NUM_CH-1:0]     ack_i,
  input logic [NUM_CH-1:0]     req_o,
  input logic [NUM_PIN_CH-1:0] sync_w,
  input logic [NUM_CH-1:0][1:0] mode_w,
  input logic [NUM_CH-1:0]     edge_w,
  input logic [NUM_CH-1:0]     pend_w
);
  // R4: codes are zero on the first cycle after reset release
  p_reset_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_w == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    if (c < NUM_PIN_CH) begin : g_pin
      p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w[c] |=> pend_w[c]);
      p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w[c] && !ack_i[c] && src_ext_i[c] && mode_w[c][0]) |=> pend_w[c]);
      p_src_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ext_i[c] |-> (!req_o[c] && !edge_w[c]));
      p_src_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ext_i[c] |=> !pend_w[c]);
      p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i[c] && !mode_w[c][0]) |-> (req_o[c] == (sync_w[c] == mode_w[c][1])));
      p_edge_needs_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w[c] |-> (sync_w[c] != $past(sync_w[c])));
    end else begin : g_nopin
      p_nopin_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o[c] == 1'b0) && (mode_w[c] == 2'b00));
    end
  end
endmodule

bind dreq_sampler dreq_sampler_chk #(.NUM_CH(NUM_CH), .NUM_PIN_CH(NUM_PIN_CH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_ext_i(src_ext_i),
  .ack_i    (ack_i),
  .req_o    (req_o),
  .sync_w   (sync_w),
  .mode_w   (mode_w),
  .edge_w   (edge_w),
  .pend_w   (pend_w)
);

// File: tb/dreq_sampler_tb.sv
module dreq_sampler_tb_top;
  localparam int NCH  = 8;
  localparam int NPIN = 4;
  localparam int CW   = $clog2(NCH);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pin = '0;
  logic [NCH-1:0]  src = '0;
  logic [NCH-1:0]  ack = '0;
  logic            wr_en = 1'b0;
  logic [CW-1:0]   wr_ch = '0;
  logic [1:0]      wr_data = '0;
  logic [CW-1:0]   rd_ch = '0;
  logic [1:0]      rd_data;
  logic [NCH-1:0]  req;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dreq_sampler #(.NUM_CH(NCH), .NUM_PIN_CH(NPIN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_pin_i(pin), .src_ext_i(src), .ack_i(ack),
    .mode_wr_en_i(wr_en), .mode_wr_ch_i(wr_ch), .mode_wr_data_i(wr_data),
    .mode_rd_ch_i(rd_ch), .mode_rd_data_o(rd_data), .req_o(req)
  );

  // bench model state
  logic [1:0] m_mode [NCH];
  logic       m_s1 [NPIN];
  logic       m_s2 [NPIN];
  logic       m_pv [NPIN];
  logic       m_pend [NCH];

  function automatic logic exp_req(input int c);
    logic lvl;
    if (c >= NPIN || !src[c]) return 1'b0;
    if (m_mode[c] == 2'd1 || m_mode[c] == 2'd3) return m_pend[c];
    lvl = (m_mode[c] == 2'd2);
    return m_s2[c] == lvl;
  endfunction

  function automatic logic [1:0] exp_code(input int c);
    return (c < NPIN) ? m_mode[c] : 2'd0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 2'd0;
      m_pend[c] = 1'b0;
    end
    for (int c = 0; c < NPIN; c++) begin
      m_s1[c] = 0; m_s2[c] = 0; m_pv[c] = 0;
    end
  endtask

  task automatic model_clock();
    for (int c = 0; c < NPIN; c++) begin
      logic hit;
      case (m_mode[c])
        2'd1:    hit = src[c] && m_pv[c] && !m_s2[c];
        2'd3:    hit = src[c] && !m_pv[c] && m_s2[c];
        default: hit = 1'b0;
      endcase
      if (hit) m_pend[c] = 1'b1;
      else if (ack[c] || !src[c] || !m_mode[c][0]) m_pend[c] = 1'b0;
      m_pv[c] = m_s2[c];
      m_s2[c] = m_s1[c];
      m_s1[c] = pin[c];
    end
    if (wr_en && int'(wr_ch) < NPIN) m_mode[wr_ch] = wr_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // one clock: inputs already driven; model advances, outputs compared at negedge
  task automatic cyc();
    logic [NCH-1:0] e;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) e[c] = exp_req(c);
    chk("R3/R5/R6/R7 req vs model", {24'd0, req}, {24'd0, e});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int ch, input logic [1:0] code);
    wr_en = 1'b1; wr_ch = CW'(ch); wr_data = code;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int ch, input logic [1:0] exp);
    rd_ch = CW'(ch);
    #1;
    chk(tag, {30'd0, rd_data}, {30'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c3a));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset req low", {24'd0, req}, 32'd0);
    rd("R4 reset code ch0", 0, 2'd0);
    rd("R4 reset code ch3", 3, 2'd0);

    // R1 read-back of every code
    for (int m = 0; m < 4; m++) begin
      wr(1, 2'(m));
      rd("R1 code readback ch1", 1, 2'(m));
    end

    // R2 channel without pin
    wr(5, 2'd3);
    rd("R2 nopin code reads 0", 5, 2'd0);
    src = '1; pin = '1;
    run(3);
    chk("R2 nopin req low", {31'd0, req[5]}, 32'd0);
    src = '0; pin = '0;
    run(3);

    // R7 level modes on ch0
    wr(0, 2'd2); src[0] = 1'b1; pin[0] = 1'b1;
    run(3);
    chk("R7 high level req", {31'd0, req[0]}, 32'd1);
    pin[0] = 1'b0;
    run(3);
    chk("R7 level released", {31'd0, req[0]}, 32'd0);
    wr(0, 2'd0);
    run(1);
    chk("R1 low level req", {31'd0, req[0]}, 32'd1);

    // R5 latency: level mode after exactly two edges
    wr(0, 2'd2);
    pin[0] = 1'b1;
    cyc();
    chk("R5 level not yet after one edge", {31'd0, req[0]}, 32'd0);
    cyc();
    chk("R5 level after two edges", {31'd0, req[0]}, 32'd1);

    // R5/R6 rising edge on ch2, merge, acknowledge
    wr(2, 2'd3); src[2] = 1'b1;
    run(3);
    chk("R6 idle no pending", {31'd0, req[2]}, 32'd0);
    pin[2] = 1'b1;
    run(2);
    chk("R5 edge not yet after two edges", {31'd0, req[2]}, 32'd0);
    cyc();
    chk("R5 edge after three edges", {31'd0, req[2]}, 32'd1);
    pin[2] = 1'b0;
    run(3);
    chk("R6 held after pin low", {31'd0, req[2]}, 32'd1);
    pin[2] = 1'b1;
    run(3);
    chk("R6 second edge merged", {31'd0, req[2]}, 32'd1);
    ack[2] = 1'b1;
    cyc();
    ack[2] = 1'b0;
    run(2);
    chk("R6 one ack clears merged", {31'd0, req[2]}, 32'd0);

    // R1 falling edge
    wr(2, 2'd1);
    pin[2] = 1'b0;
    run(3);
    chk("R1 falling edge req", {31'd0, req[2]}, 32'd1);
    ack[2] = 1'b1; cyc(); ack[2] = 1'b0;
    run(1);
    chk("R6 ack clears falling", {31'd0, req[2]}, 32'd0);

    // R8 code change under steady high pin
    wr(3, 2'd2); src[3] = 1'b1; pin[3] = 1'b1;
    run(3);
    chk("R8 level high before change", {31'd0, req[3]}, 32'd1);
    wr(3, 2'd3);
    run(4);
    chk("R8 no false edge on change", {31'd0, req[3]}, 32'd0);

    // R3 source gating
    wr(2, 2'd3); src[2] = 1'b0; pin[2] = 1'b0;
    run(3);
    pin[2] = 1'b1;
    run(4);
    chk("R3 gated edge no req", {31'd0, req[2]}, 32'd0);
    src[2] = 1'b1;
    run(2);
    chk("R3 no leftover pending", {31'd0, req[2]}, 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      pin = NPIN'($urandom);
      ack = NCH'($urandom & $urandom);
      if ((i % 16) == 0) src = NCH'($urandom);
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1; wr_ch = CW'($urandom); wr_data = 2'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      cyc();
      begin
        int rc;
        rc = int'($urandom % NCH);
        rd("R1/R2 random readback", rc, exp_code(rc));
      end
    end
    wr_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule